// File: doc/BRIEF.md
# Stretchable External Memory Bus Sequencer

This block runs one data-memory access on a multiplexed address/data bus. When the core raises a request, the block drives an address strobe and chip enable. It puts the low address byte on the shared bus and then drops the address strobe. After a setup interval it pulls the read or write strobe low. When the strobe ends, a hold interval follows, and then the block pulses a completion flag for one cycle. Reads capture the bus value at the close of the strobe. Writes drive the data from the end of the address phase until the hold interval ends.

The block is clocked by a tick that is half a system clock, so all half-clock offsets are whole tick counts. A 3-bit stretch value, sampled when a request is accepted, sets the timing. Stretch 0 gives the fastest access. Stretch 1 to 3 widens the strobe by four clocks per step. Stretch 4 to 7 widens it the same way and also inserts several extra clocks of setup and hold.

Top module: `extbus_seq`

In the requirements below, S is the sampled stretch and one tick is one `clk` period. Tick 1 is the first cycle after the edge that accepts a request.

## Requirements
- R1: During and right after reset, `ale` is 0, `rdN`, `wrN` and `ceN` are 1, `adOe`, `adKeep` and `done` are 0, and `rdData` is 0.
- R2: An accepted access holds `ale` high for exactly ticks 1 and 2. In tick 1, `adOut` equals `reqAddr[7:0]` with `adOe`=1, `addrHi` equals `reqAddr[15:8]`, and `ceN` is 0.
- R3: The strobe first goes low at tick 3+T_s, where T_s is 1 for S=0, 2 for S in 1..3 and 10 for S in 4..7.
- R4: The strobe stays low for 4 ticks when S=0 and for 8*S ticks otherwise.
- R5: `ceN` stays low from tick 1 and first rises C ticks after the strobe rises, where C is 1 for S=0, 3 for S in 1..3 and 11 for S in 4..7.
- R6: On a write, `adOut` equals `reqWdata` with `adOe`=1 when `wrN` falls. The bus stays driven until H ticks after `wrN` rises, where H is 2 for S=0, 4 for S in 1..3 and 12 for S in 4..7.
- R7: On a read, `adOe` is 0 from tick 3 onward. `adKeep` is 1 only between the fall of `ale` and the fall of `rdN`, and is 0 from the fall of `rdN` onward.
- R8: On a read, `rdData` holds the value `adIn` had in the last tick that `rdN` was low, and keeps it after `adIn` changes.
- R9: `done` is high for exactly one tick, H ticks after the strobe rises.
- R10: A request, stretch or address change that arrives while an access is in progress has no effect. The timing of the current access is unchanged, and no new access starts after `done`.
- R11: `rdN` and `wrN` are never low together. Only the strobe that matches `reqWrite` at acceptance is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, half a system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted only when idle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| stretch | input | 3 | Stretch setting, sampled at acceptance |
| done | output | 1 | One-tick completion pulse |
| rdData | output | 8 | Captured read data |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ceN | output | 1 | Chip enable, active low |
| addrHi | output | 8 | High address byte |
| adOut | output | 8 | Value driven on the multiplexed bus |
| adOe | output | 1 | Strong drive enable for the bus |
| adKeep | output | 1 | Weak hold enable for the bus during read setup |
| adIn | input | 8 | Value sampled from the multiplexed bus |

## Verification
The hardest case to reach is an input change in the middle of an access. A new request, a different stretch value or another address must leave the running access and its successor untouched. In every access, the stimulus raises `req` again in tick 4 and inverts the stretch and the address. It then measures every edge position against the figures from the stretch sampled at acceptance. The sweep covers all eight stretch values in both directions with several address/data patterns. On reads, the bus input is inverted as soon as the strobe ends, so a late capture shows up as wrong data.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  localparam int STRETCH_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phaseT;

  typedef enum logic [1:0] {
    BAND_FAST,
    BAND_MID,
    BAND_SLOW
  } bandT;

  // Strobes from the sequencer control to the bus datapath
  typedef struct packed {
    logic ale;
    logic rdStb;
    logic wrStb;
    logic ce;
    logic driveAddr;
    logic driveData;
    logic keep;
    logic capture;
    logic load;
    logic done;
  } busCtlT;

  function automatic bandT bandOf(input logic [STRETCH_W-1:0] s);
    if (s == '0) return BAND_FAST;
    else if (s < STRETCH_W'(4)) return BAND_MID;
    else return BAND_SLOW;
  endfunction

endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ALE_TICKS   = 2,
  parameter int SETUP_FAST  = 1,
  parameter int SETUP_MID   = 2,
  parameter int SETUP_SLOW  = 10,
  parameter int STROBE_FAST = 4,
  parameter int STROBE_STEP = 8,
  parameter int HOLD_FAST   = 2,
  parameter int HOLD_MID    = 4,
  parameter int HOLD_SLOW   = 12,
  parameter int CEOFF_FAST  = 1,
  parameter int CEOFF_MID   = 3,
  parameter int CEOFF_SLOW  = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 req,
  input  logic                 reqWrite,
  input  logic [STRETCH_W-1:0] stretch,
  output busCtlT               ctl
);

  localparam int MAX_STROBE = STROBE_STEP * ((1 << STRETCH_W) - 1);
  localparam int MAX_LEN    = MAX_STROBE + HOLD_SLOW + SETUP_SLOW + ALE_TICKS;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  phaseT                state, stateNext;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     phaseLen;
  logic [CNT_W-1:0]     setupLen, strobeLen, holdLen, ceOffLen;
  logic [STRETCH_W-1:0] stretchQ;
  logic                 writeQ;
  logic                 lastTick;
  bandT                 band;

  assign band = bandOf(stretchQ);

  always_comb begin
    unique case (band)
      BAND_FAST: begin
        setupLen  = CNT_W'(SETUP_FAST);
        strobeLen = CNT_W'(STROBE_FAST);
        holdLen   = CNT_W'(HOLD_FAST);
        ceOffLen  = CNT_W'(CEOFF_FAST);
      end
      BAND_MID: begin
        setupLen  = CNT_W'(SETUP_MID);
        strobeLen = CNT_W'(STROBE_STEP * int'(stretchQ));
        holdLen   = CNT_W'(HOLD_MID);
        ceOffLen  = CNT_W'(CEOFF_MID);
      end
      default: begin
        setupLen  = CNT_W'(SETUP_SLOW);
        strobeLen = CNT_W'(STROBE_STEP * int'(stretchQ));
        holdLen   = CNT_W'(HOLD_SLOW);
        ceOffLen  = CNT_W'(CEOFF_SLOW);
      end
    endcase
  end

  always_comb begin
    unique case (state)
      PH_ADDR:   phaseLen = CNT_W'(ALE_TICKS);
      PH_SETUP:  phaseLen = setupLen;
      PH_STROBE: phaseLen = strobeLen;
      PH_HOLD:   phaseLen = holdLen;
      default:   phaseLen = CNT_W'(1);
    endcase
  end

  assign lastTick = (cnt == phaseLen - CNT_W'(1));

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_IDLE:   if (req) stateNext = PH_ADDR;
      PH_ADDR:   if (lastTick) stateNext = PH_SETUP;
      PH_SETUP:  if (lastTick) stateNext = PH_STROBE;
      PH_STROBE: if (lastTick) stateNext = PH_HOLD;
      PH_HOLD:   if (lastTick) stateNext = PH_DONE;
      default:   stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      stretchQ <= '0;
      writeQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state) cnt <= '0;
      else if (state != PH_IDLE) cnt <= cnt + CNT_W'(1);
      if (state == PH_IDLE && req) begin
        stretchQ <= stretch;
        writeQ   <= reqWrite;
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.ale       = (state == PH_ADDR);
    ctl.rdStb     = (state == PH_STROBE) && !writeQ;
    ctl.wrStb     = (state == PH_STROBE) && writeQ;
    ctl.ce        = (state == PH_ADDR) || (state == PH_SETUP) || (state == PH_STROBE)
                    || ((state == PH_HOLD) && (cnt < ceOffLen));
    ctl.driveAddr = (state == PH_ADDR);
    ctl.driveData = writeQ && ((state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD));
    ctl.keep      = !writeQ && (state == PH_SETUP);
    ctl.capture   = (state == PH_STROBE) && !writeQ && lastTick;
    ctl.load      = (state == PH_IDLE) && req;
    ctl.done      = (state == PH_DONE);
  end

  // R10
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE && $past(state) != PH_IDLE) |-> $stable(stretchQ) && $stable(writeQ));

  // R4
  strobe_min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rdStb || ctl.wrStb) |=> (ctl.rdStb || ctl.wrStb));

  // R10
  no_load_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (state == PH_IDLE));

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtlT            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ceN,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              adKeep
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdQ <= adIn;
    end
  end

  always_comb begin
    if (ctl.driveAddr)      adOut = addrQ[DATA_W-1:0];
    else if (ctl.driveData) adOut = wdataQ;
    else                    adOut = '0;
  end

  assign adOe   = ctl.driveAddr || ctl.driveData;
  assign adKeep = ctl.keep;
  assign addrHi = addrQ[ADDR_W-1:DATA_W];
  assign rdData = rdQ;
  assign done   = ctl.done;
  assign ale    = ctl.ale;
  assign rdN    = !ctl.rdStb;
  assign wrN    = !ctl.wrStb;
  assign ceN    = !ctl.ce;

  // R11
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R2
  ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));

  // R5
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !ceN);

  // R7
  read_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!adOe && !adKeep));

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && $past(rdN)) |-> $stable(rdData));

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWdata,
  input  logic [2:0]  stretch,
  output logic        done,
  output logic [7:0]  rdData,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic        ceN,
  output logic [7:0]  addrHi,
  output logic [7:0]  adOut,
  output logic        adOe,
  output logic        adKeep,
  input  logic [7:0]  adIn
);

  busCtlT ctl;

  extbus_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .reqWrite (reqWrite),
    .stretch  (stretch),
    .ctl      (ctl)
  );

  extbus_datapath #(.ADDR_W(16), .DATA_W(8)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .adIn     (adIn),
    .rdData   (rdData),
    .done     (done),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .ceN      (ceN),
    .addrHi   (addrHi),
    .adOut    (adOut),
    .adOe     (adOe),
    .adKeep   (adKeep)
  );

endmodule

// File: tb/extbus_seq_tb.sv
`timescale 1ns/1ps
module extbus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [2:0]  stretch = '0;
  logic [7:0]  adIn = '0;
  logic        done, ale, rdN, wrN, ceN, adOe, adKeep;
  logic [7:0]  rdData, addrHi, adOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  extbus_seq dut_i (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .stretch(stretch), .done(done), .rdData(rdData),
    .ale(ale), .rdN(rdN), .wrN(wrN), .ceN(ceN), .addrHi(addrHi), .adOut(adOut),
    .adOe(adOe), .adKeep(adKeep), .adIn(adIn)
  );

  function automatic int expSetup(int s);
    return (s == 0) ? 1 : (s < 4) ? 2 : 10;
  endfunction
  function automatic int expWidth(int s);
    return (s == 0) ? 4 : 8 * s;
  endfunction
  function automatic int expHold(int s);
    return (s == 0) ? 2 : (s < 4) ? 4 : 12;
  endfunction
  function automatic int expCeOff(int s);
    return (s == 0) ? 1 : (s < 4) ? 3 : 11;
  endfunction

  task automatic chk(input bit ok, input string reqTag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", reqTag, act, exp);
    end
  endtask

  task automatic runCycle(input bit wr, input int s, input logic [15:0] a, input logic [7:0] d);
    int aleFirst = 0, aleCnt = 0, aleAfter = 0, stbFirst = 0, stbCnt = 0, wrongStb = 0;
    int ceRise = 0, oeFall = 0, doneTick = 0, doneCnt = 0, readBad = 0;
    bit addrOk = 0, ceLowStart = 0, oeAtStb = 0;
    logic [7:0] dataAtStb = '0;
    int tr;
    @(negedge clk);
    reqWrite = wr; stretch = 3'(s); reqAddr = a; reqWdata = d; req = 1'b1;
    adIn = ~d;
    for (int t = 1; t < 400; t++) begin
      logic stb, other;
      @(negedge clk);
      if (t == 1) req = 1'b0;
      if (t == 4) begin req = 1'b1; stretch = ~3'(s); reqAddr = ~a; reqWdata = ~d; reqWrite = ~wr; end
      if (t == 5) req = 1'b0;
      if (ale) begin
        if (aleFirst == 0) aleFirst = t;
        aleCnt++;
        if (doneTick != 0) aleAfter++;
      end
      if (t == 1) begin
        addrOk = (adOut == a[7:0]) && adOe && (addrHi == a[15:8]);
        ceLowStart = !ceN;
      end
      stb = wr ? wrN : rdN;
      other = wr ? rdN : wrN;
      if (!other) wrongStb++;
      if (!stb) begin
        if (stbFirst == 0) begin
          stbFirst = t; dataAtStb = adOut; oeAtStb = adOe;
        end
        stbCnt++;
      end
      if (t > 1 && ceN && ceRise == 0) ceRise = t;
      if (wr && t >= 3 && !adOe && oeFall == 0) oeFall = t;
      if (!wr && t >= 3 && doneTick == 0) begin
        if (adOe) readBad++;
        if (stbFirst == 0 && !adKeep) readBad++;
        if (stbFirst != 0 && adKeep) readBad++;
      end
      if (done) begin
        doneCnt++;
        if (doneTick == 0) doneTick = t;
      end
      if (!wr) adIn = !rdN ? d : ~d;
      if (doneTick != 0 && t == doneTick + 3) break;
    end
    tr = 3 + expSetup(s) + expWidth(s);
    // R2
    chk(aleFirst == 1 && aleCnt == 2 && addrOk && ceLowStart, "R2", aleCnt, 2);
    // R3
    chk(stbFirst == 3 + expSetup(s), "R3", stbFirst, 3 + expSetup(s));
    // R4
    chk(stbCnt == expWidth(s), "R4", stbCnt, expWidth(s));
    // R5
    chk(ceRise == tr + expCeOff(s), "R5", ceRise, tr + expCeOff(s));
    if (wr) begin
      // R6
      chk(dataAtStb == d && oeAtStb, "R6", int'(dataAtStb), int'(d));
      chk(oeFall == tr + expHold(s), "R6", oeFall, tr + expHold(s));
    end else begin
      // R7
      chk(readBad == 0, "R7", readBad, 0);
      // R8
      chk(rdData == d, "R8", int'(rdData), int'(d));
    end
    // R9
    chk(doneTick == tr + expHold(s) && doneCnt == 1, "R9", doneTick, tr + expHold(s));
    // R10
    chk(aleAfter == 0, "R10", aleAfter, 0);
    // R11
    chk(wrongStb == 0, "R11", wrongStb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!ale && rdN && wrN && ceN && !adOe && !adKeep && !done && rdData == 8'h00,
        "R1", int'({ale, rdN, wrN, ceN, adOe, adKeep, done}), 7'b0111000);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ale && rdN && wrN && ceN && !adOe && !adKeep && !done,
        "R1", int'({ale, rdN, wrN, ceN, adOe, adKeep, done}), 7'b0111000);
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int w = 0; w < 2; w++) begin
          logic [15:0] a;
          logic [7:0] d;
          a = 16'h1234 ^ 16'(p * 16'h5A5A + s * 16'h0101);
          d = (p == 2) ? 8'h00 : 8'(8'hA5 ^ (p * 8'hFF) ^ s);
          runCycle(w[0], s, a, d);
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule